// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds one 32-bit control word for each pin of a bank of general-purpose pins, grouped into ports, and serves those words on a simple 32-bit register bus. Each word chooses the pin's pull resistor, whether the driver is push-pull or open-drain, the direction, which of four sources owns the pad (plain GPIO or one of three alternate peripheral signals), and the level driven when the GPIO logic owns the pad. The same word reports the pad's level as seen through a two-flop synchronizer.

The pad side of the block drives an output value, an output enable and the two pull controls for each pin, and takes the raw pad input. The alternate peripherals are not part of the block. They appear only as a value and an enable per pin and per function, and the mux selects among them. Software programs a pin with one word write. All fields of that write take effect together on the clock edge that accepts it.

Top module: `gpio_ctl_bank`

## Requirements
- R1: The word of pin `s` in port `p` sits at byte address `p*0x20 + s*4`, and address bits 1:0 are ignored. A write changes only the addressed pin's word and pad. Pin `s` of port `p` is pad index `p*PINS_PER_PORT + s`.
- R2: After reset every word reads 0x0000_0400: input direction with the input sample enabled, no pull, function 0. No pad is driven and no pull is active.
- R3: Only bits 1:0 (pull), 8 (open-drain), 9 (output), 10 (input sample enable), 13:12 (function) and 16 (level) keep written values. Every other bit reads 0, except bit 24 as given in R10.
- R4: An address whose slot field (bits 4:2) is at least PINS_PER_PORT, or whose port field (bits ADDR_W-1:5) is at least NUM_PORTS, reads 0. A write to such an address changes no word and no pad.
- R5: Read data appears on `busRdData` on the clock edge that samples `busRdEn` and holds until the next read.
- R6: A pull field of 01 asserts `padPullUp`, 10 asserts `padPullDown`, and 00 or 11 asserts neither.
- R7: With function 0, bit 9 set and bit 8 clear, the pad is driven (`padOe`=1) with `padOut` equal to bit 16. With bit 9 clear and function 0, `padOe` is 0.
- R8: With bit 8 set, `padOut` is 0 and the pad is enabled only while the selected source's value is 0. A value of 1 releases the pad.
- R9: A function value k of 1 to 3 routes `altOut`/`altOe` bit `pin*3 + k-1` to the pad, and bits 9 and 16 have no effect. R8 still applies.
- R10: Bit 24 reads the pad input after two register stages while bit 10 is set, and reads 0 while bit 10 is clear.
- R11: One write that sets open-drain, output and level together produces the final pad state on the next clock edge, with no intermediate state visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| padIn | input | NUM_PORTS*PINS_PER_PORT | Raw pad input levels |
| altOut | input | NUM_PORTS*PINS_PER_PORT*3 | Alternate peripheral values, three per pin |
| altOe | input | NUM_PORTS*PINS_PER_PORT*3 | Alternate peripheral enables, three per pin |
| padOut | output | NUM_PORTS*PINS_PER_PORT | Pad output value |
| padOe | output | NUM_PORTS*PINS_PER_PORT | Pad output enable |
| padPullUp | output | NUM_PORTS*PINS_PER_PORT | Pull-up enable |
| padPullDown | output | NUM_PORTS*PINS_PER_PORT | Pull-down enable |

## Verification
The bench builds the bank with three ports of six pins and an 8-bit address. This leaves slots 6 and 7 of each port empty and ports 3 to 7 unmapped, so both kinds of address hole from R4 can be reached inside the decoded range. Eighteen pins are not a power of two, so the flat pin index crosses port boundaries at non-aligned values. The bench exercises this through the neighbour checks of R1 and through alternate-signal indexing on a pin in port 1.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  // field positions inside one pin word
  localparam int PULL_LSB  = 0;
  localparam int OD_BIT    = 8;
  localparam int DIR_BIT   = 9;
  localparam int INEN_BIT  = 10;
  localparam int FUNC_LSB  = 12;
  localparam int LEVEL_BIT = 16;
  localparam int PAD_BIT   = 24;

  localparam logic [31:0] STORE_MASK = 32'h0001_3703;
  localparam logic [31:0] RESET_WORD = 32'h0000_0400;

  localparam logic [1:0] PULL_UP_CODE   = 2'b01;
  localparam logic [1:0] PULL_DOWN_CODE = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic wrStb;
    logic rdStb;
    logic hit;
  } regStrobe_t;
endpackage

// File: rtl/gpio_ctl_decode.sv
module gpio_ctl_decode
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 8,
  parameter int ADDR_W        = 8,
  localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT,
  localparam int PIN_IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  output regStrobe_t           strb,
  output logic [PIN_IDX_W-1:0] pinSel
);
  logic [ADDR_W-6:0] portIdx;
  logic [2:0]        slotIdx;
  logic [1:0]        unusedAddrBits;
  int unsigned       flatIdx;

  assign portIdx        = busAddr[ADDR_W-1:5];
  assign slotIdx        = busAddr[4:2];
  assign unusedAddrBits = busAddr[1:0];

  always_comb begin
    flatIdx    = int'(portIdx) * PINS_PER_PORT + int'(slotIdx);
    pinSel     = flatIdx[PIN_IDX_W-1:0];
    strb.hit   = (int'(portIdx) < NUM_PORTS) && (int'(slotIdx) < PINS_PER_PORT);
    strb.wrStb = busWrEn;
    strb.rdStb = busRdEn;
  end
endmodule

// File: rtl/gpio_ctl_datapath.sv
module gpio_ctl_datapath
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 8,
  localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT,
  localparam int NUM_ALT      = NUM_PINS * 3,
  localparam int PIN_IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [PIN_IDX_W-1:0] pinSel,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_PINS-1:0]  padIn,
  input  logic [NUM_ALT-1:0]   altOut,
  input  logic [NUM_ALT-1:0]   altOe,
  output logic [NUM_PINS-1:0]  padOut,
  output logic [NUM_PINS-1:0]  padOe,
  output logic [NUM_PINS-1:0]  padPullUp,
  output logic [NUM_PINS-1:0]  padPullDown
);
  logic [31:0]         ctlWord [NUM_PINS];
  logic [NUM_PINS-1:0] padMeta;
  logic [NUM_PINS-1:0] padSync;
  logic [31:0]         selWord;

  // all fields of one write land on the same edge
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (!rstN) begin
        ctlWord[p] <= RESET_WORD;
      end else if (strb.wrStb && strb.hit && (int'(pinSel) == p)) begin
        ctlWord[p] <= busWrData & STORE_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      padMeta <= '0;
      padSync <= '0;
    end else begin
      padMeta <= padIn;
      padSync <= padMeta;
    end
  end

  always_comb begin
    selWord = '0;
    if (strb.hit) begin
      selWord = ctlWord[pinSel];
      selWord[PAD_BIT] = padSync[pinSel] & ctlWord[pinSel][INEN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strb.rdStb) begin
      busRdData <= selWord;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    localparam int BASE = p * 3;
    logic [1:0] func;
    logic [1:0] pull;
    logic       srcOe;
    logic       srcVal;
    logic       odMode;

    assign func   = ctlWord[p][FUNC_LSB +: 2];
    assign pull   = ctlWord[p][PULL_LSB +: 2];
    assign odMode = ctlWord[p][OD_BIT];

    always_comb begin
      case (func)
        2'd1:    begin srcOe = altOe[BASE];     srcVal = altOut[BASE];     end
        2'd2:    begin srcOe = altOe[BASE + 1]; srcVal = altOut[BASE + 1]; end
        2'd3:    begin srcOe = altOe[BASE + 2]; srcVal = altOut[BASE + 2]; end
        default: begin srcOe = ctlWord[p][DIR_BIT]; srcVal = ctlWord[p][LEVEL_BIT]; end
      endcase
    end

    assign padOe[p]       = odMode ? (srcOe & ~srcVal) : srcOe;
    assign padOut[p]      = odMode ? 1'b0 : srcVal;
    assign padPullUp[p]   = (pull == PULL_UP_CODE);
    assign padPullDown[p] = (pull == PULL_DOWN_CODE);
  end
endmodule

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 8,
  parameter int ADDR_W        = 8,
  localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT,
  localparam int NUM_ALT      = NUM_PINS * 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_ALT-1:0]  altOut,
  input  logic [NUM_ALT-1:0]  altOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDown
);
  localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  regStrobe_t           strb;
  logic [PIN_IDX_W-1:0] pinSel;

  gpio_ctl_decode #(
    .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT), .ADDR_W(ADDR_W)
  ) u_decode (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .strb(strb), .pinSel(pinSel)
  );

  gpio_ctl_datapath #(
    .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .pinSel(pinSel),
    .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .altOut(altOut), .altOe(altOe),
    .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDown(padPullDown)
  );
endmodule

// File: rtl/gpio_ctl_bank_checker.sv
module gpio_ctl_bank_checker #(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 8,
  parameter int ADDR_W        = 8,
  localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busRdData,
  input logic [NUM_PINS-1:0] padPullUp,
  input logic [NUM_PINS-1:0] padPullDown
);
  logic unmapped;
  assign unmapped = (int'(busAddr[ADDR_W-1:5]) >= NUM_PORTS) ||
                    (int'(busAddr[4:2]) >= PINS_PER_PORT);

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && unmapped |=> busRdData == 32'h0); // R4

  AST_MISS_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && unmapped |=> $stable(padPullUp) && $stable(padPullDown)); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData)); // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> (busRdData & ~32'h0101_3703) == 32'h0); // R3

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDown) == '0); // R6
endmodule

bind gpio_ctl_bank gpio_ctl_bank_checker #(
  .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT), .ADDR_W(ADDR_W)
) u_checker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busRdData(busRdData),
  .padPullUp(padPullUp), .padPullDown(padPullDown)
);

// File: tb/gpio_ctl_bank_bench.sv
`timescale 1ns/1ps
module gpio_ctl_bank_bench;
  localparam int NP = 3;
  localparam int PP = 6;
  localparam int AW = 8;
  localparam int NPIN = NP * PP;
  localparam int NALT = NPIN * 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busWrEn = 1'b0;
  logic            busRdEn = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [NPIN-1:0] padIn = '0;
  logic [NALT-1:0] altOut = '0;
  logic [NALT-1:0] altOe = '0;
  logic [NPIN-1:0] padOut, padOe, padPullUp, padPullDown;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_ctl_bank #(.NUM_PORTS(NP), .PINS_PER_PORT(PP), .ADDR_W(AW)) u_gpio_ctl_bank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .altOut(altOut), .altOe(altOe),
    .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDown(padPullDown)
  );

  function automatic logic [AW-1:0] pinAddr(int port, int slot);
    return AW'(port * 32 + slot * 4);
  endfunction

  function automatic int flat(int port, int slot);
    return port * PP + slot;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(logic [AW-1:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doRead(pinAddr(0, 0), d);  check("R2 word p0s0", d, 32'h400);
    doRead(pinAddr(2, 5), d);  check("R2 word p2s5", d, 32'h400);
    check("R2 oe", 32'(padOe), 32'h0);
    check("R2 pulls", 32'(padPullUp | padPullDown), 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    doWrite(pinAddr(0, 6), 32'h0001_0201);
    doWrite(pinAddr(3, 0), 32'h0001_0201);
    check("R4 no oe after miss write", 32'(padOe), 32'h0);
    check("R4 no pull after miss write", 32'(padPullUp), 32'h0);
    doRead(pinAddr(0, 6), d);  check("R4 slot hole reads 0", d, 32'h0);
    doRead(pinAddr(3, 0), d);  check("R4 port hole reads 0", d, 32'h0);
    doRead(pinAddr(1, 0), d);  check("R4 neighbour untouched", d, 32'h400);
  endtask

  task automatic testMask();
    logic [31:0] d;
    doWrite(pinAddr(0, 3), 32'hFFFF_FFFF);
    doRead(pinAddr(0, 3), d);  check("R3 stored bits only", d, 32'h0001_3703);
    doWrite(pinAddr(0, 3), 32'h400);
    doRead(pinAddr(0, 3), d);  check("R3 restore", d, 32'h400);
  endtask

  task automatic testMap();
    logic [31:0] d;
    doWrite(pinAddr(1, 2) | AW'(3), 32'h0001_0200);
    doRead(pinAddr(1, 2), d);  check("R1 target word", d, 32'h0001_0200);
    doRead(pinAddr(1, 1), d);  check("R1 lower neighbour", d, 32'h400);
    doRead(pinAddr(1, 3), d);  check("R1 upper neighbour", d, 32'h400);
    doRead(pinAddr(0, 2), d);  check("R1 other port", d, 32'h400);
    check("R1 pad index", 32'(padOe), 32'(1) << flat(1, 2));
    doWrite(pinAddr(1, 2), 32'h400);
  endtask

  task automatic testPull();
    int f = flat(2, 1);
    doWrite(pinAddr(2, 1), 32'h401);
    check("R6 up", {30'b0, padPullUp[f], padPullDown[f]}, 32'h2);
    doWrite(pinAddr(2, 1), 32'h402);
    check("R6 down", {30'b0, padPullUp[f], padPullDown[f]}, 32'h1);
    doWrite(pinAddr(2, 1), 32'h403);
    check("R6 code 11 none", {30'b0, padPullUp[f], padPullDown[f]}, 32'h0);
    doWrite(pinAddr(2, 1), 32'h400);
    check("R6 code 00 none", {30'b0, padPullUp[f], padPullDown[f]}, 32'h0);
  endtask

  task automatic testPushPull();
    int f = flat(0, 4);
    doWrite(pinAddr(0, 4), 32'h0001_0200);
    check("R7 drive high", {30'b0, padOe[f], padOut[f]}, 32'h3);
    doWrite(pinAddr(0, 4), 32'h0000_0200);
    check("R7 drive low", {30'b0, padOe[f], padOut[f]}, 32'h2);
    doWrite(pinAddr(0, 4), 32'h0001_0400);
    check("R7 input not driven", {31'b0, padOe[f]}, 32'h0);
  endtask

  task automatic testOpenDrain();
    int f = flat(0, 5);
    doWrite(pinAddr(0, 5), 32'h0000_0300);
    check("R8 od low pulls", {30'b0, padOe[f], padOut[f]}, 32'h2);
    doWrite(pinAddr(0, 5), 32'h0001_0300);
    check("R8 od high releases", {30'b0, padOe[f], padOut[f]}, 32'h0);
    doWrite(pinAddr(0, 5), 32'h400);
  endtask

  task automatic testAlt();
    int f = flat(1, 1);
    altOut[f*3 + 1] = 1'b1; altOe[f*3 + 1] = 1'b1;
    altOe[f*3 + 2]  = 1'b1;
    doWrite(pinAddr(1, 1), 32'h0000_2000);
    check("R9 func2 drives alt", {30'b0, padOe[f], padOut[f]}, 32'h3);
    doWrite(pinAddr(1, 1), 32'h0001_3000);
    check("R9 func3 ignores level", {30'b0, padOe[f], padOut[f]}, 32'h2);
    doWrite(pinAddr(1, 1), 32'h0000_2100);
    check("R9 func2 open-drain releases", {30'b0, padOe[f], padOut[f]}, 32'h0);
    doWrite(pinAddr(1, 1), 32'h0000_1200);
    check("R9 func1 idle source", {30'b0, padOe[f], padOut[f]}, 32'h0);
    doWrite(pinAddr(1, 1), 32'h400);
    altOut = '0; altOe = '0;
  endtask

  task automatic testSync();
    logic [31:0] d;
    padIn[flat(0, 0)] = 1'b1;
    doRead(pinAddr(0, 0), d);  check("R10 edge1 old", d, 32'h400);
    doRead(pinAddr(0, 0), d);  check("R10 edge2 old", d, 32'h400);
    doRead(pinAddr(0, 0), d);  check("R10 edge3 new", d, 32'h0100_0400);
    doWrite(pinAddr(0, 0), 32'h0);
    doRead(pinAddr(0, 0), d);  check("R10 gated off", d, 32'h0);
    doWrite(pinAddr(0, 0), 32'h400);
    padIn = '0;
  endtask

  task automatic testHold();
    logic [31:0] d;
    doWrite(pinAddr(2, 2), 32'h0000_0201);
    doRead(pinAddr(2, 2), d);
    check("R5 read value", d, 32'h0000_0201);
    busAddr = pinAddr(0, 0);
    @(negedge clk);
    check("R5 hold without read", busRdData, 32'h0000_0201);
    doWrite(pinAddr(2, 2), 32'h400);
  endtask

  task automatic testAtomic();
    int f = flat(2, 3);
    busWrEn = 1'b1; busAddr = pinAddr(2, 3); busWrData = 32'h0001_0300;
    @(posedge clk);
    #1;
    check("R11 all fields at once", {30'b0, padOe[f], padOut[f]}, 32'h0);
    @(negedge clk);
    busWrEn = 1'b0;
    doWrite(pinAddr(2, 3), 32'h0000_0300);
    check("R11 od low after one write", {30'b0, padOe[f], padOut[f]}, 32'h2);
    doWrite(pinAddr(2, 3), 32'h400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnmapped();
    testMask();
    testMap();
    testPull();
    testPushPull();
    testOpenDrain();
    testAlt();
    testSync();
    testHold();
    testAtomic();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule